// File: doc/BRIEF.md
# Iterative Fibonacci Accelerator

The block computes the Fibonacci number F(N) for an index N supplied by a producer. It works one iteration per clock cycle. Two running registers advance from (0, 1). A down-counter tracks how many iterations remain. The block handles one request at a time.

The index arrives on a valid/ready handshake. The result leaves on a valid/acknowledge handshake. After the block accepts an index, it refuses new indices. It stays busy until the consumer acknowledges the result, and only then returns to idle. Sums wrap modulo 2^RES_W.

Reset is active low and synchronous: it acts only on a rising clock edge.

Top module: `fib_accel`

## Requirements
- R1: After a clock edge with `rst_ni` low, the block is idle: `idx_rdy_o` = 1, `res_vld_o` = 0 and `res_o` = 0.
- R2: The index is captured on a rising edge where `idx_vld_i` and `idx_rdy_o` are both 1. From the next cycle, `idx_rdy_o` is 0.
- R3: With F(0)=0, F(1)=1 and F(n)=F(n-1)+F(n-2), the value on `res_o` while `res_vld_o` is 1 equals F(N) mod 2^RES_W, where N is the captured index.
- R4: `res_vld_o` rises exactly max(1, N) clock edges after the capture edge.
- R5: While `res_vld_o` is 1 and `res_ack_i` is 0, `res_vld_o` stays 1 and `res_o` stays unchanged.
- R6: After an edge where `res_vld_o` and `res_ack_i` are both 1, `res_vld_o` is 0 and `idx_rdy_o` is 1.
- R7: An `idx_vld_i` pulse or a change of `idx_i` while the block is busy has no effect: the result and its timing follow the captured index, and `idx_rdy_o` stays 0 until the acknowledge.
- R8: `idx_rdy_o` and `res_vld_o` are never 1 together.
- R9: Driving `rst_ni` low during a computation returns the block to the R1 state at the next edge. A new request afterwards completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| idx_i | input | IDX_W | Index N to compute |
| idx_vld_i | input | 1 | Producer presents a valid index |
| idx_rdy_o | output | 1 | Block can accept an index |
| res_o | output | RES_W | Result F(N) mod 2^RES_W |
| res_vld_o | output | 1 | Result valid, held until acknowledged |
| res_ack_i | input | 1 | Consumer has read the result |

## Verification
The directed indices are 0, 1, 2 and 3. They separate the two shortcut exits from the first iterating case, and they expose off-by-one errors in the counter and in the final register selection. Index 47 is the largest whose result fits 32 bits. Indices 48 and 255 check that the sums wrap. Random indices with random acknowledge delays check that the result holds steady during long waits. Index changes and valid pulses injected during the busy phase show whether a busy block captures anything. A reset in the middle of a computation checks that the synchronous return to idle is clean.

// File: rtl/fib_pkg.sv
package fib_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } fib_state_e;
endpackage

// File: rtl/fib_ctrl.sv
module fib_ctrl
  import fib_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  input  logic ack_i,
  output logic idle_o,
  output logic step_o,
  output logic finish_o,
  output logic done_o
);
  fib_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (last_i)  state_d = ST_DONE;
      ST_DONE: if (ack_i)   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign step_o   = (state_q == ST_RUN) && !last_i;
  assign finish_o = (state_q == ST_RUN) && last_i;
endmodule

// File: rtl/fib_steps.sv
module fib_steps #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] val_i,
  input  logic             dec_i,
  output logic             last_o,
  output logic             zero_o
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  // one step left (or none): final cycle selects the answer
  assign last_o = (cnt_q <= ONE);
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fib_pair.sv
module fib_pair #(
  parameter int unsigned RES_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             step_i,
  input  logic             finish_i,
  input  logic             pick_lo_i,
  output logic [RES_W-1:0] res_o
);
  logic [RES_W-1:0] lo_q, hi_q, res_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      res_q <= '0;
    end else begin
      if (init_i) begin
        lo_q <= '0;
        hi_q <= RES_W'(1);
      end else if (step_i) begin
        lo_q <= hi_q;
        hi_q <= lo_q + hi_q;   // wraps mod 2^RES_W
      end
      if (finish_i) res_q <= pick_lo_i ? lo_q : hi_q;
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/fib_accel.sv
module fib_accel #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned RES_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             idx_vld_i,
  output logic             idx_rdy_o,
  output logic [RES_W-1:0] res_o,
  output logic             res_vld_o,
  input  logic             res_ack_i
);
  logic idle, step, finish, done, last, zero, start;

  assign start = idx_vld_i && idle;

  fib_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .last_i   (last),
    .ack_i    (res_ack_i),
    .idle_o   (idle),
    .step_o   (step),
    .finish_o (finish),
    .done_o   (done)
  );

  fib_steps #(.IDX_W(IDX_W)) u_steps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .val_i  (idx_i),
    .dec_i  (step),
    .last_o (last),
    .zero_o (zero)
  );

  fib_pair #(.RES_W(RES_W)) u_pair (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (start),
    .step_i    (step),
    .finish_i  (finish),
    .pick_lo_i (zero),
    .res_o     (res_o)
  );

  assign idx_rdy_o = idle;
  assign res_vld_o = done;
endmodule

// File: rtl/fib_accel_chk.sv
module fib_accel_chk #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned RES_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] idx_i,
  input logic             idx_vld_i,
  input logic             idx_rdy_o,
  input logic [RES_W-1:0] res_o,
  input logic             res_vld_o,
  input logic             res_ack_i
);
  localparam int unsigned LW = IDX_W + 1;

  logic          busy_q;
  logic [LW-1:0] lat_q, exp_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      lat_q  <= '0;
      exp_q  <= '0;
    end else if (idx_vld_i && idx_rdy_o) begin
      busy_q <= 1'b1;
      lat_q  <= '0;
      exp_q  <= (idx_i <= IDX_W'(1)) ? LW'(1) : LW'(idx_i);
    end else if (busy_q && !res_vld_o) begin
      lat_q <= lat_q + LW'(1);
    end else if (res_vld_o && res_ack_i) begin
      busy_q <= 1'b0;
    end
  end

  // R2
  capture_drops_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_vld_i && idx_rdy_o |=> !idx_rdy_o);

  // R4
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $rose(res_vld_o) |-> lat_q == exp_q);

  // R5
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o && !res_ack_i |=> res_vld_o && $stable(res_o));

  // R6
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o && res_ack_i |=> !res_vld_o && idx_rdy_o);

  // R8
  exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(idx_rdy_o && res_vld_o));

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |=> idx_rdy_o && !res_vld_o && res_o == '0);
endmodule

bind fib_accel fib_accel_chk #(.IDX_W(IDX_W), .RES_W(RES_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .idx_i     (idx_i),
  .idx_vld_i (idx_vld_i),
  .idx_rdy_o (idx_rdy_o),
  .res_o     (res_o),
  .res_vld_o (res_vld_o),
  .res_ack_i (res_ack_i)
);

// File: tb/fib_accel_test.sv
module fib_accel_test;
  localparam int IDX_W = 8;
  localparam int RES_W = 32;
  localparam int WATCHDOG = 150000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [IDX_W-1:0] idx_i = '0;
  logic             idx_vld_i = 1'b0;
  logic             idx_rdy_o;
  logic [RES_W-1:0] res_o;
  logic             res_vld_o;
  logic             res_ack_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  fib_accel #(.IDX_W(IDX_W), .RES_W(RES_W)) uut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [RES_W-1:0] fib_ref(int n);
    logic [RES_W-1:0] a = '0, b = RES_W'(1), t;
    for (int i = 0; i < n; i++) begin
      t = a + b; a = b; b = t;
    end
    return a;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      report();
    end
  end

  task automatic run(int n, int ack_wait, bit poke);
    int lat = 0;
    logic [RES_W-1:0] held;
    while (!idx_rdy_o) @(negedge clk_i);
    idx_i = IDX_W'(n); idx_vld_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    idx_vld_i = 1'b0;
    check("R2 rdy low after capture", idx_rdy_o, 0);
    while (!res_vld_o && lat < 1000) begin
      if (poke) begin
        idx_i = IDX_W'($urandom_range(0, 255)); idx_vld_i = $urandom_range(0, 1);
      end
      @(posedge clk_i); lat++; @(negedge clk_i);
    end
    idx_vld_i = 1'b0;
    check("R4 latency", lat, (n <= 1) ? 1 : n);
    check("R3 value", res_o, fib_ref(n));
    check("R8 rdy with vld", idx_rdy_o, 0);
    held = res_o;
    for (int i = 0; i < ack_wait; i++) begin
      if (poke) begin
        idx_i = IDX_W'($urandom_range(0, 255)); idx_vld_i = 1'b1;
      end
      @(posedge clk_i); @(negedge clk_i);
      check("R5 vld held", res_vld_o, 1);
      check("R5 result held", res_o, held);
      if (poke) check("R7 busy ignores input", idx_rdy_o, 0);
    end
    idx_vld_i = 1'b0;
    res_ack_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    res_ack_i = 1'b0;
    check("R6 vld low after ack", res_vld_o, 0);
    check("R6 rdy high after ack", idx_rdy_o, 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 rdy after reset", idx_rdy_o, 1);
    check("R1 vld after reset", res_vld_o, 0);
    check("R1 res after reset", res_o, 0);
    rst_ni = 1'b1;

    run(0, 0, 0);
    run(1, 2, 0);
    run(2, 1, 0);
    run(3, 3, 1);
    run(47, 1, 0);
    run(48, 2, 0);    // R3 wrap
    run(255, 4, 1);   // R3 wrap, R7 busy pokes

    for (int k = 0; k < 40; k++)
      run($urandom_range(0, 90), $urandom_range(0, 5), 1'($urandom_range(0, 1)));

    // R9 reset mid-computation
    @(negedge clk_i);
    idx_i = 8'd200; idx_vld_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    idx_vld_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    check("R9 rdy after mid reset", idx_rdy_o, 1);
    check("R9 vld after mid reset", res_vld_o, 0);
    check("R9 res after mid reset", res_o, 0);
    rst_ni = 1'b1;
    run(10, 1, 0);

    report();
  end
endmodule